// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the serial transmit line of a host UART into the short-pulse signalling used by serial infrared links. Timing comes from a bit-tick enable that fires sixteen times per bit. A falling edge on the idle host line opens a frame of ten bit cells: the start bit, eight data bits and the stop bit. Each cell is sixteen ticks long. A zero cell carries one high pulse that begins after the seventh tick and lasts three ticks. A one cell stays dark.

At low baud rates three ticks is a long time for an emitter to be on. A limiter counts system clocks from the rising edge of each pulse and ends the pulse after a set number of cycles, about 4 µs at the default clock. The link is half duplex: while the companion decoder reports an incoming pulse, the output is held low. Once the stop cell ends, the encoder goes idle and waits for the next falling edge, so the tick rate may change between frames.

Top module: `sir_pulse_encoder`

## Requirements
- R1: Within one frame, every cell is exactly 16 tick periods long. The rising edges of the pulses for any two zero cells lie an exact multiple of 16 tick periods apart.
- R2: In a zero cell, ir_pulse rises one clock after the 7th tick of the cell is consumed. While 3 tick periods are shorter than LIMIT_CYCLES, it stays high for exactly 3 tick periods.
- R3: A frame has 10 cells in this order: start, 8 data, stop. The value of each cell is the synchronized host_tx level when the cell's 7th tick is consumed. A cell whose value is 1 produces no pulse.
- R4: The first pulse of a frame rises 7 or 8 tick periods after host_tx falls while the encoder is idle. Falling edges of host_tx during a frame do not move the cell grid.
- R5: ir_pulse never stays high for more than LIMIT_CYCLES clocks. When 3 tick periods would last longer, the pulse is exactly LIMIT_CYCLES clocks long and stays low for the rest of that cell.
- R6: While rx_active is high, ir_pulse is low from the next clock on. A pulse cut short this way does not resume within the same cell.
- R7: While rst_n is low, ir_pulse is low. The reset is asynchronous and takes effect without waiting for a clock.
- R8: After the 10th cell the encoder is idle and ir_pulse stays low. A host_tx line that stays low does not start another frame. Only a new falling edge does, and the tick period may differ from the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle enable, sixteen per bit time |
| host_tx | input | 1 | Serial line from the host UART, asynchronous, idle high |
| rx_active | input | 1 | Decoder is seeing an incoming pulse (half-duplex lockout) |
| ir_pulse | output | 1 | Pulse drive toward the optical transmitter |

## Verification
The assertions assume two things. First, bit_tick is a single-cycle pulse with at least four clocks between ticks, so that a start edge is detected before the next tick arrives. Second, the host line is held steady for whole bit times, so the value sampled at the 7th tick is the intended bit. The stimulus generates ticks from a divider of 4 to 10 clocks, and the divider only changes while the encoder is idle. It drives every bit for exactly 16 tick periods, starting at a random phase relative to the ticks. Lockout is exercised by holding rx_active across a whole frame, and the limiter by tick periods whose three-tick pulse is longer than the cycle limit.

// File: rtl/sir_enc_pkg.sv
`timescale 1ns/1ps
package sir_enc_pkg;
  // Tick position lies inside the pulse slot [first, first+width).
  function automatic logic in_slot(input int unsigned pos,
                                   input int unsigned first,
                                   input int unsigned width);
    return (pos >= first) && (pos < first + width);
  endfunction

  // Clock-cycle count of an unlimited pulse, given the tick period.
  function automatic int unsigned raw_pulse_cycles(input int unsigned tick_period,
                                                   input int unsigned pulse_ticks);
    return tick_period * pulse_ticks;
  endfunction

  // Pulse length once the limiter has been applied.
  function automatic int unsigned limited_cycles(input int unsigned raw,
                                                 input int unsigned limit);
    return (raw < limit) ? raw : limit;
  endfunction
endpackage

// File: rtl/sir_tx_sync.sv
`timescale 1ns/1ps
module sir_tx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_tx,
  output logic tx_level,
  output logic tx_fall
);
  // Shift chain: SYNC_STAGES synchronizer flops plus one history flop.
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], host_tx};
  end

  assign tx_level = chain_q[SYNC_STAGES-1];
  assign tx_fall  = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/sir_cell_seq.sv
`timescale 1ns/1ps
module sir_cell_seq #(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_BITS    = 10,
  parameter int SAMPLE_POS    = 7,
  localparam int POS_W = $clog2(TICKS_PER_BIT),
  localparam int IDX_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_fall,
  input  logic             tx_level,
  output logic             busy,
  output logic [POS_W-1:0] pos,
  output logic             bit_zero
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(TICKS_PER_BIT - 1);
  localparam logic [POS_W-1:0] POS_SAMP = POS_W'(SAMPLE_POS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             frame_start;
  logic             cell_end;
  logic             sample_now;

  assign frame_start = !busy && tx_fall;
  assign cell_end    = busy && bit_tick && (pos == POS_LAST);
  assign sample_now  = busy && bit_tick && (pos == POS_SAMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pos   <= '0;
      idx_q <= '0;
    end else if (frame_start) begin
      busy  <= 1'b1;
      pos   <= '0;
      idx_q <= '0;
    end else if (cell_end) begin
      pos <= '0;
      if (idx_q == IDX_LAST) busy  <= 1'b0;
      else                   idx_q <= idx_q + 1'b1;
    end else if (busy && bit_tick) begin
      pos <= pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bit_zero <= 1'b0;
    else if (sample_now) bit_zero <= ~tx_level;
  end

  AST_CELL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cell_end |=> (pos == '0)); // R1
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> $stable(pos)); // R1
  AST_NO_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_fall && !bit_tick) |=> $stable(pos) && busy); // R4
endmodule

// File: rtl/sir_pulse_shaper.sv
`timescale 1ns/1ps
module sir_pulse_shaper
  import sir_enc_pkg::*;
#(
  parameter int POS_W        = 4,
  parameter int PULSE_START  = 7,
  parameter int PULSE_TICKS  = 3,
  parameter int LIMIT_CYCLES = 800,
  localparam int CNT_W = $clog2(LIMIT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [POS_W-1:0] pos,
  input  logic             bit_zero,
  input  logic             rx_busy,
  output logic             txir
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT_CYCLES - 1);

  logic [CNT_W-1:0] hi_cnt;
  logic             cut_q;
  logic             slot_win;
  logic             limit_hit;
  logic             drive_next;

  assign slot_win   = busy && bit_zero &&
                      in_slot(32'(pos), PULSE_START, PULSE_TICKS);
  assign limit_hit  = txir && (hi_cnt == CNT_LAST);
  assign drive_next = slot_win && !cut_q && !limit_hit && !rx_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txir   <= 1'b0;
      hi_cnt <= '0;
      cut_q  <= 1'b0;
    end else begin
      txir   <= drive_next;
      hi_cnt <= txir ? hi_cnt + 1'b1 : '0;
      if (!slot_win)                   cut_q <= 1'b0;
      else if (limit_hit || rx_busy)   cut_q <= 1'b1;
    end
  end

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |=> !txir); // R6
  AST_ONE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_zero |=> !txir); // R3
  AST_RISE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txir) |-> ($past(pos) == POS_W'(PULSE_START))); // R2
  AST_LIMIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (txir && hi_cnt == CNT_LAST) |=> !txir); // R5
  AST_NO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_q && slot_win) |=> !txir); // R6
endmodule

// File: rtl/sir_pulse_encoder.sv
`timescale 1ns/1ps
module sir_pulse_encoder #(
  parameter int TICKS_PER_BIT = 16,
  parameter int FRAME_BITS    = 10,
  parameter int PULSE_START   = 7,
  parameter int PULSE_TICKS   = 3,
  parameter int LIMIT_CYCLES  = 800,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic host_tx,
  input  logic rx_active,
  output logic ir_pulse
);
  localparam int POS_W = $clog2(TICKS_PER_BIT);

  logic             tx_level;
  logic             tx_fall;
  logic             seq_busy;
  logic [POS_W-1:0] seq_pos;
  logic             seq_zero;

  sir_tx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_tx  (host_tx),
    .tx_level (tx_level),
    .tx_fall  (tx_fall)
  );

  sir_cell_seq #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .FRAME_BITS    (FRAME_BITS),
    .SAMPLE_POS    (PULSE_START)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .tx_fall  (tx_fall),
    .tx_level (tx_level),
    .busy     (seq_busy),
    .pos      (seq_pos),
    .bit_zero (seq_zero)
  );

  sir_pulse_shaper #(
    .POS_W        (POS_W),
    .PULSE_START  (PULSE_START),
    .PULSE_TICKS  (PULSE_TICKS),
    .LIMIT_CYCLES (LIMIT_CYCLES)
  ) u_shaper (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (seq_busy),
    .pos      (seq_pos),
    .bit_zero (seq_zero),
    .rx_busy  (rx_active),
    .txir     (ir_pulse)
  );

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |=> !ir_pulse); // R8
endmodule

// File: tb/sir_pulse_encoder_bench.sv
`timescale 1ns/1ps
module sir_pulse_encoder_bench;
  localparam int LIMIT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic host_tx = 1'b1;
  logic rx_active = 1'b0;
  logic ir_pulse;

  always #2.5 clk = ~clk;

  sir_pulse_encoder #(.LIMIT_CYCLES(LIMIT)) u_sir_pulse_encoder (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .host_tx(host_tx), .rx_active(rx_active), .ir_pulse(ir_pulse)
  );

  // Tick generator: one pulse every tick_div clocks.
  int tick_div = 4;
  int div_cnt  = 0;
  always @(posedge clk) begin
    div_cnt  <= (div_cnt >= tick_div - 1) ? 0 : div_cnt + 1;
    bit_tick <= (div_cnt == 0);
  end

  // Observer, sampled on the falling clock edge.
  int cyc = 0, tick_obs = 0, base_tick = 0;
  int nrise = 0, nwidth = 0, hi_run = 0;
  logic want_base = 1'b0, tx_seen = 1'b1, ir_seen = 1'b0;
  int rise_cyc [64];
  int rise_tk  [64];
  int width_c  [64];

  always @(negedge clk) begin
    cyc++;
    if (bit_tick) tick_obs++;
    if (want_base && tx_seen && !host_tx) begin
      base_tick = tick_obs;
      want_base = 1'b0;
    end
    if (ir_pulse && !ir_seen && nrise < 64) begin
      rise_cyc[nrise] = cyc;
      rise_tk[nrise]  = tick_obs - base_tick;
      nrise++;
    end
    if (ir_pulse) hi_run++;
    else if (ir_seen) begin
      if (nwidth < 64) begin width_c[nwidth] = hi_run; nwidth++; end
      hi_run = 0;
    end
    tx_seen = host_tx;
    ir_seen = ir_pulse;
  end

  int n_tests = 0, n_fail = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_width(input int d);
    return (3 * d < LIMIT) ? 3 * d : LIMIT;
  endfunction

  function automatic int count_zero(input logic [9:0] cells);
    int n = 0;
    for (int i = 0; i < 10; i++) if (!cells[i]) n++;
    return n;
  endfunction

  function automatic logic [9:0] make_cells(input logic [7:0] data);
    return {1'b1, data, 1'b0};
  endfunction

  task automatic clear_obs();
    nrise = 0; nwidth = 0; hi_run = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input logic [9:0] cells, input int d, input logic lock);
    int exp_n, k;
    string wtag;
    wait_cyc(1);
    tick_div  = d;
    rx_active = lock;
    wait_cyc(3 * 16 * d);
    clear_obs();
    want_base = 1'b1;
    wait_cyc(1 + $urandom_range(0, d - 1));
    for (int i = 0; i < 10; i++) begin
      host_tx = cells[i];
      wait_cyc(16 * d);
    end
    host_tx = 1'b1;
    wait_cyc(3 * 16 * d);
    rx_active = 1'b0;
    exp_n = lock ? 0 : count_zero(cells);
    check(lock ? "R6" : "R3", "pulse count in frame", nrise, exp_n);
    if (!lock && nrise == exp_n && nrise > 0) begin
      check("R4", "first rise 7..8 ticks after start edge",
            int'(rise_tk[0] == 7 || rise_tk[0] == 8), 1);
      k = 0;
      for (int i = 0; i < 10; i++) begin
        if (!cells[i]) begin
          check("R1", "rise offset in cycles", rise_cyc[k] - rise_cyc[0], i * 16 * d);
          k++;
        end
      end
      wtag = (3 * d < LIMIT) ? "R2" : "R5";
      for (int j = 0; j < nwidth; j++)
        check(wtag, "pulse width in cycles", width_c[j], exp_width(d));
      check(wtag, "width count", nwidth, exp_n);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed_v;
    int got;
    seed_v = $urandom(32'h5EED);
    // R7: reset holds the output low
    wait_cyc(10);
    check("R7", "ir_pulse during reset", int'(ir_pulse), 0);
    rst_n = 1'b1;
    wait_cyc(10);

    // Directed frames
    run_frame(make_cells(8'hFF), 4, 1'b0);   // R3 only the start cell pulses
    run_frame(make_cells(8'h55), 7, 1'b0);   // R4 R1 mid-frame falls, limiter edge
    run_frame(make_cells(8'h00), 10, 1'b0);  // R5 limited pulses
    run_frame(make_cells(8'h00), 4, 1'b0);   // R2 unlimited pulses
    run_frame(make_cells(8'h3C), 5, 1'b1);   // R6 lockout for whole frame
    run_frame(make_cells(8'h3C), 5, 1'b0);   // R6 recovers after lockout

    // R8: a steady low line gives one frame only
    wait_cyc(1);
    tick_div = 5;
    wait_cyc(3 * 16 * 5);
    clear_obs();
    host_tx = 1'b0;
    wait_cyc(40 * 16 * 5);
    check("R8", "pulses with line held low", nrise, 10);
    host_tx = 1'b1;
    wait_cyc(3 * 16 * 5);
    check("R8", "no pulse after line returns high", nrise, 10);
    run_frame(make_cells(8'hA5), 6, 1'b0);   // R8 new frame at a new tick rate

    // R7: asynchronous reset during a pulse
    wait_cyc(1);
    tick_div = 10;
    wait_cyc(3 * 16 * 10);
    host_tx = 1'b0;
    got = 0;
    for (int i = 0; i < 2000 && !got; i++) begin
      @(negedge clk);
      if (ir_pulse) got = 1;
    end
    check("R7", "pulse seen before reset", got, 1);
    #1 rst_n = 1'b0;
    #1 check("R7", "ir_pulse right after reset", int'(ir_pulse), 0);
    host_tx = 1'b1;
    wait_cyc(20);
    check("R7", "ir_pulse held in reset", int'(ir_pulse), 0);
    rst_n = 1'b1;
    wait_cyc(20);

    // Random frames
    for (int n = 0; n < 12; n++) begin
      run_frame(make_cells(8'($urandom())), int'($urandom_range(4, 10)), 1'b0);
    end
    finish_run();
  end
endmodule